// File: doc/BRIEF.md
# MFM Write Stream Escape Formatter

This block sits between a DMA source and the MFM bit-cell encoder of a floppy write channel. It takes the outgoing track image as 16-bit words, unpacks each word high byte first, and hands the encoder one byte for every byte slot the encoder requests. Control travels in-band. A word whose high byte is the escape value 0x99 is not data. Its low byte is a command that emits a mark byte with a missing clock, emits the running CRC, opens a raw window in which escapes are not recognised, or ends the write.

A write starts with a one-cycle `start` pulse, which raises the write gate. A typical sector image contains the following, in order:
- a run of gap words,
- a zero-filled sync field,
- three A1 marks and the FB data mark,
- the raw-window command and 512 data bytes,
- the CRC command, a short gap and the stop command.

The block keeps a CRC-16 over the marks and the data. Mark bytes are flagged on `out_mark` so that the encoder can suppress their clock bit. If the encoder asks for a byte and none is staged, the write is aborted and an underrun flag is raised.

Top module: `mfmf_formatter`

## Requirements
- R1: After reset, `wr_gate`, `out_stb`, `out_mark`, `underrun` and `in_ready` are all low.
- R2: A `start` pulse while `wr_gate` is low raises `wr_gate` on the next cycle and clears `underrun`. `in_ready` is high only while `wr_gate` is high and no output byte is staged. While idle, offered words are not taken.
- R3: Outside escapes, each word produces two unmarked output bytes, bits 15:8 first and then bits 7:0. Each `byte_tick` that finds a byte staged produces exactly one `out_stb` pulse, in the cycle after the tick.
- R4: The escape word 0x99A1 emits one byte 0xA1 with `out_mark` high. The escape word 0x99C2 emits one byte 0xC2 with `out_mark` high. No other byte is ever marked.
- R5: An escape word whose low byte is not one of 0xA1, 0xC2, 0x04, 0x08 or 0x0F emits that low byte as one unmarked data byte. For example, 0x99FB emits 0xFB and 0x99FC emits 0xFC.
- R6: The escape word 0x990F emits nothing. The next 512 bytes (256 words) pass through as plain data even where a high byte is 0x99, and this includes the words 0x9904 and 0x9908.
- R7: The CRC is CRC-16 with polynomial 0x1021, shifted MSB first. It is preset to 0xFFFF at an A1 mark that does not directly follow another A1 mark. It covers A1 marks and every unmarked data byte after the preset, but not C2 marks and not CRC bytes. The escape word 0x9904 emits the CRC as two unmarked bytes, high byte first.
- R8: The escape word 0x9908 emits nothing, drops `wr_gate` in the cycle after it is taken, and ends the write. After that no byte is output and no further word is taken.
- R9: A `byte_tick` while `wr_gate` is high and no byte is staged produces no strobe. It sets `underrun` and drops `wr_gate`. `underrun` stays high until the next `start`.
- R10: Escapes are recognised only in the high byte of a word. A low byte of 0x99 is ordinary data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a write operation (taken only while idle) |
| in_valid | input | 1 | Source word available |
| in_word | input | 16 | Source word, high byte sent first |
| in_ready | output | 1 | Word taken at this edge when in_valid is high |
| byte_tick | input | 1 | Encoder requests the next byte |
| out_stb | output | 1 | Output byte valid for one cycle |
| out_byte | output | 8 | Output byte for the encoder |
| out_mark | output | 1 | Output byte is a mark with a missing clock |
| wr_gate | output | 1 | Write gate to the head |
| underrun | output | 1 | Write aborted because no byte was ready |

## Verification
On every cycle, the checker confirms that a strobe answers a tick that was made while the gate was open. It also confirms that only A1 and C2 leave with the mark flag, that words are taken only while writing, that the gate opens only after a start pulse, and that an underrun always closes the gate. Which bytes appear is a different matter. The escape decoding, the 512-byte raw window with embedded 0x99 words, the CRC value and its preset point, and the silence after the stop code depend on whole word sequences. Only the bench scenarios can show these, by comparing each byte against a stream model.

// File: rtl/mfmf_pkg.sv
// Shared types, command codes and the CRC step for the MFM write formatter.
// Assumes byte-serial CRC, MSB first.
package mfmf_pkg;

    typedef enum logic [1:0] {
        K_DATA = 2'd0,   // plain byte, covered by the CRC
        K_SYNC = 2'd1,   // A1 mark, presets and feeds the CRC
        K_MARK = 2'd2,   // other mark (C2), outside the CRC
        K_CRC  = 2'd3    // CRC byte, outside the CRC
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [7:0] val;
    } item_t;

    localparam logic [7:0] ESC_BYTE  = 8'h99;
    localparam logic [7:0] CMD_SYNC  = 8'hA1;
    localparam logic [7:0] CMD_INDEX = 8'hC2;
    localparam logic [7:0] CMD_CRC   = 8'h04;
    localparam logic [7:0] CMD_STOP  = 8'h08;
    localparam logic [7:0] CMD_RAW   = 8'h0F;

    // One byte of CRC-16, MSB first, for a given polynomial.
    function automatic logic [15:0] crc_step(input logic [15:0] cur,
                                             input logic [7:0]  d,
                                             input logic [15:0] poly);
        logic [15:0] r;
        r = cur ^ {d, 8'h00};
        for (int i = 0; i < 8; i++) begin
            r = r[15] ? ((r << 1) ^ poly) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/mfmf_decode.sv
// Word decoder: turns one source word into zero, one or two output items,
// plus raw-window and stop requests.
// Assumes escapes are aligned to the word's high byte.
module mfmf_decode
    import mfmf_pkg::*;
(
    input  logic [15:0] word,
    input  logic        raw_active,
    input  logic [15:0] crc,
    output logic [1:0]  n_items,
    output item_t       item0,
    output item_t       item1,
    output logic        raw_go,
    output logic        stop_go
);
    logic [7:0] hi;
    logic [7:0] lo;

    assign hi = word[15:8];
    assign lo = word[7:0];

    // Classify the word and build its output items.
    always_comb begin
        n_items = 2'd2;
        item0   = '{kind: K_DATA, val: hi};
        item1   = '{kind: K_DATA, val: lo};
        raw_go  = 1'b0;
        stop_go = 1'b0;
        if (!raw_active && hi == ESC_BYTE) begin
            item1 = '{kind: K_DATA, val: 8'h00};
            unique case (lo)
                CMD_SYNC: begin
                    n_items = 2'd1;
                    item0   = '{kind: K_SYNC, val: lo};
                end
                CMD_INDEX: begin
                    n_items = 2'd1;
                    item0   = '{kind: K_MARK, val: lo};
                end
                CMD_CRC: begin
                    n_items = 2'd2;
                    item0   = '{kind: K_CRC, val: crc[15:8]};
                    item1   = '{kind: K_CRC, val: crc[7:0]};
                end
                CMD_STOP: begin
                    n_items = 2'd0;
                    stop_go = 1'b1;
                end
                CMD_RAW: begin
                    n_items = 2'd0;
                    raw_go  = 1'b1;
                end
                default: begin
                    n_items = 2'd1;
                    item0   = '{kind: K_DATA, val: lo};
                end
            endcase
        end
    end

endmodule

// File: rtl/mfmf_stage.sv
// Two-entry staging buffer between the decoder and the output register.
// Assumes load happens only when empty (the top guarantees this), so load
// and pop never meet.
module mfmf_stage
    import mfmf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       load,
    input  logic [1:0] n_items,
    input  item_t      item0,
    input  item_t      item1,
    input  logic       pop,
    output logic [1:0] count,
    output item_t      head
);
    item_t slot0;
    item_t slot1;

    // Fill from a decoded word, or shift one item out per pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot0 <= '{kind: K_DATA, val: 8'h00};
            slot1 <= '{kind: K_DATA, val: 8'h00};
            count <= 2'd0;
        end else if (clr) begin
            count <= 2'd0;
        end else if (load) begin
            slot0 <= item0;
            slot1 <= item1;
            count <= n_items;
        end else if (pop) begin
            slot0 <= slot1;
            count <= count - 2'd1;
        end
    end

    assign head = slot0;

endmodule

// File: rtl/mfmf_crc.sv
// Running CRC over the emitted byte stream.
// A1 marks preset the register unless they follow another A1.
// Data bytes feed it; C2 marks and CRC bytes leave it untouched.
module mfmf_crc
    import mfmf_pkg::*;
#(
    parameter logic [15:0] POLY = 16'h1021,
    parameter logic [15:0] INIT = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        upd,
    input  item_t       item,
    output logic [15:0] crc
);
    logic prev_sync;

    // Advance the CRC as each byte leaves the block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc       <= INIT;
            prev_sync <= 1'b0;
        end else if (clr) begin
            crc       <= INIT;
            prev_sync <= 1'b0;
        end else if (upd) begin
            unique case (item.kind)
                K_DATA: begin
                    crc       <= crc_step(crc, item.val, POLY);
                    prev_sync <= 1'b0;
                end
                K_SYNC: begin
                    crc       <= crc_step(prev_sync ? crc : INIT, item.val, POLY);
                    prev_sync <= 1'b1;
                end
                default: prev_sync <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/mfmf_formatter.sv
// Top of the MFM write formatter. Controls the write gate, the raw window
// and underrun, and registers one output byte per encoder tick.
// Assumes the encoder leaves a few cycles between ticks, so that a word can
// be decoded between two byte slots.
module mfmf_formatter
    import mfmf_pkg::*;
#(
    parameter int          RAW_BYTES = 512,
    parameter logic [15:0] CRC_POLY  = 16'h1021,
    parameter logic [15:0] CRC_INIT  = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        in_valid,
    input  logic [15:0] in_word,
    output logic        in_ready,
    input  logic        byte_tick,
    output logic        out_stb,
    output logic [7:0]  out_byte,
    output logic        out_mark,
    output logic        wr_gate,
    output logic        underrun
);
    localparam int RAW_W = $clog2(RAW_BYTES + 1);
    localparam logic [RAW_W-1:0] RAW_LOAD = RAW_W'(RAW_BYTES);
    localparam logic [RAW_W-1:0] RAW_STEP = RAW_W'(2);

    logic [RAW_W-1:0] raw_left;
    logic             raw_active;
    logic [15:0]      crc;
    logic [1:0]       n_items;
    item_t            item0;
    item_t            item1;
    item_t            head;
    logic [1:0]       count;
    logic             raw_go;
    logic             stop_go;
    logic             start_go;
    logic             load;
    logic             pop;

    assign raw_active = (raw_left != '0);
    assign start_go   = start && !wr_gate;
    assign in_ready   = wr_gate && (count == 2'd0);
    assign load       = in_valid && in_ready;
    assign pop        = wr_gate && byte_tick && (count != 2'd0);

    mfmf_decode u_dec (
        .word       (in_word),
        .raw_active (raw_active),
        .crc        (crc),
        .n_items    (n_items),
        .item0      (item0),
        .item1      (item1),
        .raw_go     (raw_go),
        .stop_go    (stop_go)
    );

    mfmf_stage u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start_go),
        .load    (load),
        .n_items (n_items),
        .item0   (item0),
        .item1   (item1),
        .pop     (pop),
        .count   (count),
        .head    (head)
    );

    mfmf_crc #(
        .POLY (CRC_POLY),
        .INIT (CRC_INIT)
    ) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_go),
        .upd   (pop),
        .item  (head),
        .crc   (crc)
    );

    // Write gate, raw window, underrun and the registered byte output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_gate  <= 1'b0;
            underrun <= 1'b0;
            raw_left <= '0;
            out_stb  <= 1'b0;
            out_byte <= 8'h00;
            out_mark <= 1'b0;
        end else begin
            out_stb  <= 1'b0;
            out_mark <= 1'b0;
            if (!wr_gate) begin
                if (start) begin
                    wr_gate  <= 1'b1;
                    underrun <= 1'b0;
                    raw_left <= '0;
                end
            end else begin
                if (byte_tick) begin
                    if (count != 2'd0) begin
                        out_stb  <= 1'b1;
                        out_byte <= head.val;
                        out_mark <= (head.kind == K_SYNC) || (head.kind == K_MARK);
                    end else begin
                        underrun <= 1'b1;
                        wr_gate  <= 1'b0;
                    end
                end
                if (load) begin
                    if (raw_active) begin
                        raw_left <= raw_left - RAW_STEP;
                    end else if (raw_go) begin
                        raw_left <= RAW_LOAD;
                    end
                    if (stop_go) begin
                        wr_gate <= 1'b0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/mfmf_chk.sv
// Cycle-level properties of the MFM write formatter, bound to its top.
module mfmf_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        in_ready,
    input logic        byte_tick,
    input logic        out_stb,
    input logic [7:0]  out_byte,
    input logic        out_mark,
    input logic        wr_gate,
    input logic        underrun
);
    // R3
    stb_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_stb |-> $past(byte_tick) && $past(wr_gate));

    // R4
    mark_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_mark |-> out_stb && (out_byte == 8'hA1 || out_byte == 8'hC2));

    // R2
    ready_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> wr_gate);

    // R2
    gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_gate) |-> $past(start));

    // R9
    underrun_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> !wr_gate && $past(wr_gate) && $past(byte_tick));

    // R9
    underrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(underrun) |-> $past(start));
endmodule

bind mfmf_formatter mfmf_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_ready  (in_ready),
    .byte_tick (byte_tick),
    .out_stb   (out_stb),
    .out_byte  (out_byte),
    .out_mark  (out_mark),
    .wr_gate   (wr_gate),
    .underrun  (underrun)
);

// File: tb/sim_mfmf_formatter.sv
module sim_mfmf_formatter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = 16'h0000;
    logic        in_ready;
    logic        byte_tick = 1'b0;
    logic        out_stb;
    logic [7:0]  out_byte;
    logic        out_mark;
    logic        wr_gate;
    logic        underrun;

    int checks = 0;
    int errors = 0;

    logic [15:0] src_q[$];
    logic [8:0]  exp_q[$];   // {mark, byte}
    logic        feed_en = 1'b0;
    logic        tick_en = 1'b0;
    int          tick_cnt = 0;

    // Stream model state
    logic [15:0] m_crc;
    bit          m_prev_sync;
    int          m_raw;
    bit          m_stopped;

    always #5 clk = ~clk;

    mfmf_formatter u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .in_ready  (in_ready),
        .byte_tick (byte_tick),
        .out_stb   (out_stb),
        .out_byte  (out_byte),
        .out_mark  (out_mark),
        .wr_gate   (wr_gate),
        .underrun  (underrun)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] m_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int b = 7; b >= 0; b--) begin
            if (r[15] ^ d[b]) r = (r << 1) ^ 16'h1021;
            else              r = r << 1;
        end
        return r;
    endfunction

    // kind: 0 data, 1 A1 mark, 2 C2 mark, 3 crc byte
    task automatic push_exp(input int kind, input logic [7:0] v);
        case (kind)
            0: begin m_crc = m_step(m_crc, v); m_prev_sync = 0; end
            1: begin m_crc = m_step(m_prev_sync ? m_crc : 16'hFFFF, v); m_prev_sync = 1; end
            default: m_prev_sync = 0;
        endcase
        exp_q.push_back({(kind == 1 || kind == 2), v});
    endtask

    // Driver: queue a source word and the bytes the requirements predict for it.
    task automatic send_word(input logic [15:0] w);
        logic [15:0] c;
        src_q.push_back(w);
        if (m_stopped) return;
        if (m_raw > 0) begin
            push_exp(0, w[15:8]); push_exp(0, w[7:0]); m_raw -= 2;      // R6
        end else if (w[15:8] == 8'h99) begin
            case (w[7:0])
                8'hA1: push_exp(1, 8'hA1);                               // R4
                8'hC2: push_exp(2, 8'hC2);                               // R4
                8'h04: begin c = m_crc; push_exp(3, c[15:8]); push_exp(3, c[7:0]); end // R7
                8'h08: m_stopped = 1;                                    // R8
                8'h0F: m_raw = 512;                                      // R6
                default: push_exp(0, w[7:0]);                            // R5
            endcase
        end else begin
            push_exp(0, w[15:8]); push_exp(0, w[7:0]);                   // R3, R10
        end
    endtask

    task automatic model_reset();
        m_crc = 16'hFFFF; m_prev_sync = 0; m_raw = 0; m_stopped = 0;
        src_q.delete(); exp_q.delete();
    endtask

    // Monitor: compare each strobed byte against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && out_stb) begin
            if (exp_q.size() == 0) begin
                check(0, "R8 byte after end of stream", int'(out_byte), 0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check({out_mark, out_byte} == e, "R3/R4/R7 byte stream",
                      int'({out_mark, out_byte}), int'(e));
            end
        end
    end

    // Source feeder with valid/ready handshake.
    initial begin
        bit fire;
        forever begin
            @(negedge clk);
            fire = in_valid && in_ready;
            @(posedge clk);
            #1;
            if (fire) void'(src_q.pop_front());
            in_valid = feed_en && (src_q.size() > 0);
            in_word  = (src_q.size() > 0) ? src_q[0] : 16'h0000;
        end
    end

    // Encoder byte slots: one tick every 8 cycles.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            tick_cnt++;
            byte_tick = tick_en && (tick_cnt % 8 == 0);
        end
    end

    task automatic run_write();
        int guard;
        feed_en = 1'b1;
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        check(wr_gate == 1'b1, "R2 gate after start", int'(wr_gate), 1);
        check(underrun == 1'b0, "R9 underrun cleared by start", int'(underrun), 0);
        repeat (3) @(posedge clk);
        #1 tick_en = 1'b1;
        guard = 0;
        while ((exp_q.size() != 0 || wr_gate) && guard < 20000) begin
            @(posedge clk); guard++;
        end
        repeat (40) @(posedge clk);   // more ticks: nothing may follow
        #1 tick_en = 1'b0;
        @(negedge clk);
        check(exp_q.size() == 0, "R3 all expected bytes seen", exp_q.size(), 0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!wr_gate && !out_stb && !out_mark && !underrun && !in_ready, "R1 reset state",
              int'({wr_gate, out_stb, out_mark, underrun, in_ready}), 0);
        #1 rst_n = 1'b1;

        // Idle: offered words are not taken (R2)
        model_reset();
        src_q.push_back(16'h1234);
        feed_en = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(in_ready == 1'b0 && src_q.size() == 1, "R2 idle takes nothing",
              src_q.size(), 1);

        // Full sector: gap, sync, marks, raw data with 0x99 words, CRC, stop (R3-R8)
        model_reset();
        for (int i = 0; i < 5; i++) send_word(16'h4E4E);
        for (int i = 0; i < 6; i++) send_word(16'h0000);
        for (int i = 0; i < 3; i++) send_word(16'h99A1);
        send_word(16'h99FB);
        send_word(16'h990F);
        for (int i = 0; i < 256; i++) begin
            logic [7:0] b;
            b = 8'(i);
            if (i % 4 == 0) send_word({8'h99, b});
            else            send_word({b ^ 8'h5A, b});
        end
        send_word(16'h9904);
        send_word(16'h4E4E);
        send_word(16'h4E4E);
        send_word(16'h9908);
        for (int i = 0; i < 6; i++) send_word(16'h0000);
        run_write();
        check(wr_gate == 1'b0, "R8 gate low after stop", int'(wr_gate), 0);
        check(in_ready == 1'b0, "R8 nothing taken after stop", int'(in_ready), 0);
        check(src_q.size() == 6, "R8 trailing words left untaken", src_q.size(), 6);
        check(underrun == 1'b0, "R9 no underrun on clean stop", int'(underrun), 0);

        // Header with low-byte 0x99 and an unknown code (R5, R7, R10)
        model_reset();
        for (int i = 0; i < 3; i++) send_word(16'h99A1);
        send_word(16'h99FE);
        send_word(16'h1299);
        send_word(16'h3499);
        send_word(16'h9955);
        send_word(16'h9904);
        send_word(16'h4E4E);
        send_word(16'h9908);
        run_write();
        check(wr_gate == 1'b0, "R8 header stop", int'(wr_gate), 0);

        // Index mark: C2 marks outside the CRC, FC as data (R4, R5, R7)
        model_reset();
        send_word(16'h4E4E);
        for (int i = 0; i < 3; i++) send_word(16'h99C2);
        send_word(16'h99FC);
        send_word(16'h99A1);
        send_word(16'h99C2);
        send_word(16'h99A1);
        send_word(16'h9904);
        send_word(16'h9908);
        run_write();

        // Underrun: source runs dry before the stop code (R9)
        model_reset();
        send_word(16'h4E4E);
        send_word(16'h1122);
        run_write();
        check(underrun == 1'b1, "R9 underrun raised", int'(underrun), 1);
        check(wr_gate == 1'b0, "R9 gate dropped on underrun", int'(wr_gate), 0);

        // Restart clears underrun (R9)
        model_reset();
        send_word(16'h99A1);
        send_word(16'h9904);
        send_word(16'h9908);
        run_write();
        check(underrun == 1'b0, "R9 underrun stays clear", int'(underrun), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule